// File: doc/BRIEF.md
# Write-to-Precharge Bank Timing Guard

This block guards one bank of a low-power DDR memory controller. It follows each bank activate and each write burst, and it decides in which cycle a precharge may start and in which cycle the next activate may follow. A precharge request that arrives while a write burst is still sending valid data cuts the burst short. From the next cycle on, the block masks every remaining beat and holds the strobe enable high, so that the device still captures the mask state. Write recovery is then counted from the last valid beat. A write with autoprecharge leaves the burst whole. It closes the bank on the earliest cycle that an external precharge could have used without cutting the burst.

The controller drives one-cycle command strobes: activate, write, write with autoprecharge and precharge request. The three timing limits are cycle counts taken from configuration inputs. A burst is eight beats, sent as two beats per controller clock, so it takes four data cycles. These begin in the cycle after the accepted write command. The precharge command leaves the block as a one-cycle `pre_o` pulse. A refused activate or write is dropped, and so is any request made while a precharge is already pending.

Top module: `wrpre_bank_guard`

## Requirements
- R1: After reset, `pre_ok_o`=0, `act_ok_o`=1, `pre_o`=0, `dqs_en_o`=0 and `dm_o`=00.
- R2: `act_i` opens the bank only in a cycle where `act_ok_o`=1, and is otherwise ignored. `act_ok_o` stays 0 while the bank is open.
- R3: After an activate accepted in cycle A, `pre_ok_o` and `pre_o` stay 0 before cycle A+max(cfg_tras,1).
- R4: A write accepted in cycle W drives `dqs_en_o`=1 with `dm_o`=00 in cycles W+1 to W+4. A write is accepted when the bank is open, no precharge is pending and `pre_req_i` is low in the same cycle. Any other write is ignored.
- R5: A write accepted during a burst restarts the four data cycles from the next cycle.
- R6: Let L be the cycle of the last valid data beat. `pre_ok_o` stays 0 before cycle L+1+cfg_twr, and it stays 0 while unmasked burst data is still due.
- R7: A `pre_req_i` with the bank open and nothing pending is held. It produces a single `pre_o` pulse in the first later cycle where `pre_ok_o`=1, and the bank is closed after that pulse. A `pre_req_i` with the bank closed is ignored.
- R8: A `pre_req_i` accepted in cycle c during an unmasked data cycle that is not the last one makes c the last valid cycle. `dm_o`=11 from c+1 until the burst ends, with `dqs_en_o` still 1. Bit 0 masks the rising-edge beat and bit 1 masks the falling-edge beat.
- R9: `wra_i` starts an uncut burst and issues `pre_o` in the earliest cycle where `pre_ok_o`=1. Writes and precharge requests are ignored while that precharge is pending.
- R10: After `pre_o` in cycle P, `act_ok_o` stays 0 before cycle P+max(cfg_trp,1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_twr | input | CNT_W | Write recovery, in cycles |
| cfg_tras | input | CNT_W | Minimum activate-to-precharge time, in cycles |
| cfg_trp | input | CNT_W | Precharge-to-activate time, in cycles |
| act_i | input | 1 | Activate command strobe |
| wr_i | input | 1 | Write command strobe |
| wra_i | input | 1 | Write with autoprecharge strobe |
| pre_req_i | input | 1 | Precharge request strobe |
| pre_ok_o | output | 1 | A precharge may start this cycle |
| act_ok_o | output | 1 | An activate may be accepted this cycle |
| pre_o | output | 1 | A precharge starts this cycle |
| dqs_en_o | output | 1 | Write strobe enable: a data cycle of the burst |
| dm_o | output | BEATS_PER_CLK | Per-beat data mask for the current data cycle |

## Verification
Every output is driven from state registers, so a command sampled in cycle n can first change the outputs in cycle n+1. Data cycles run from W+1 to W+4, and the mask starts at c+1 after a cut. Precharge eligibility becomes true at L+1+cfg_twr, at A+cfg_tras after an activate, and at P+cfg_trp for the next activate. The bench tracks the cycles of those events as plain integers and derives each expected output directly from these formulas. It compares all outputs in the middle of every cycle, after the edge that produced them and before it drives that cycle's inputs.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
  localparam int unsigned DEF_BURST_LEN     = 8;
  localparam int unsigned DEF_BEATS_PER_CLK = 2;
  localparam int unsigned DEF_CNT_W         = 6;
endpackage

// File: rtl/wpg_downcnt.sv
module wpg_downcnt #(
  parameter int unsigned W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic         zero_o
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (ld)        cnt <= ld_val;
    else if (cnt != '0) cnt <= cnt - W'(1);
  end

  assign zero_o = (cnt == '0);
endmodule

// File: rtl/wpg_burst.sv
module wpg_burst #(
  parameter int unsigned BURST_LEN = 8,
  parameter int unsigned BEATS     = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             cut_req,
  output logic             busy_o,
  output logic             cut_o,
  output logic             last_o,
  output logic [BEATS-1:0] mask_o
);
  localparam int unsigned BCNT_W = $clog2(BURST_LEN + 1);
  localparam logic [BCNT_W-1:0] LAST_CNT = BCNT_W'(BURST_LEN - BEATS);
  localparam logic [BCNT_W-1:0] STEP     = BCNT_W'(BEATS);

  logic [BCNT_W-1:0] bcnt;
  logic              busy, cut;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cut  <= 1'b0;
      bcnt <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cut  <= 1'b0;
      bcnt <= '0;
    end else if (busy) begin
      if (bcnt == LAST_CNT) begin
        busy <= 1'b0;
        cut  <= 1'b0;
        bcnt <= '0;
      end else begin
        bcnt <= bcnt + STEP;
        if (cut_req) cut <= 1'b1;
      end
    end
  end

  assign busy_o = busy;
  assign cut_o  = cut;
  assign last_o = busy && (bcnt == LAST_CNT);

  for (genvar b = 0; b < BEATS; b++) begin : g_beat
    assign mask_o[b] = busy && cut;
  end
endmodule

// File: rtl/wrpre_bank_guard.sv
module wrpre_bank_guard
  import wpg_pkg::*;
#(
  parameter int unsigned CNT_W         = DEF_CNT_W,
  parameter int unsigned BURST_LEN     = DEF_BURST_LEN,
  parameter int unsigned BEATS_PER_CLK = DEF_BEATS_PER_CLK
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [CNT_W-1:0]         cfg_twr,
  input  logic [CNT_W-1:0]         cfg_tras,
  input  logic [CNT_W-1:0]         cfg_trp,
  input  logic                     act_i,
  input  logic                     wr_i,
  input  logic                     wra_i,
  input  logic                     pre_req_i,
  output logic                     pre_ok_o,
  output logic                     act_ok_o,
  output logic                     pre_o,
  output logic                     dqs_en_o,
  output logic [BEATS_PER_CLK-1:0] dm_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic active, pend;
  logic ras_zero, rp_zero, wr_zero;
  logic busy, cut, last;
  logic uncut_busy, pre_ok, pre_fire, act_ok;
  logic act_acc, pre_acc, wr_acc, cut_req, wr_ld;
  logic [CNT_W-1:0] tras_ld, trp_ld;

  assign tras_ld = (cfg_tras == '0) ? '0 : cfg_tras - ONE;
  assign trp_ld  = (cfg_trp  == '0) ? '0 : cfg_trp  - ONE;

  assign uncut_busy = busy && !cut;
  assign pre_ok     = active && ras_zero && wr_zero && !uncut_busy;
  assign pre_fire   = pend && pre_ok;
  assign act_ok     = !active && rp_zero;

  assign act_acc = act_i && act_ok;
  assign pre_acc = pre_req_i && active && !pend;
  assign wr_acc  = (wr_i || wra_i) && active && !pend && !pre_req_i;
  assign cut_req = pre_acc && uncut_busy;
  assign wr_ld   = (uncut_busy && last && !wr_acc) || cut_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      pend   <= 1'b0;
    end else begin
      if (act_acc)       active <= 1'b1;
      else if (pre_fire) active <= 1'b0;
      if (pre_fire)                         pend <= 1'b0;
      else if (pre_acc || (wr_acc && wra_i)) pend <= 1'b1;
    end
  end

  wpg_downcnt #(.W(CNT_W)) u_ras (
    .clk(clk), .rst(rst), .ld(act_acc), .ld_val(tras_ld), .zero_o(ras_zero)
  );

  wpg_downcnt #(.W(CNT_W)) u_rp (
    .clk(clk), .rst(rst), .ld(pre_fire), .ld_val(trp_ld), .zero_o(rp_zero)
  );

  wpg_downcnt #(.W(CNT_W)) u_wr (
    .clk(clk), .rst(rst), .ld(wr_ld), .ld_val(cfg_twr), .zero_o(wr_zero)
  );

  wpg_burst #(.BURST_LEN(BURST_LEN), .BEATS(BEATS_PER_CLK)) u_burst (
    .clk(clk), .rst(rst), .start(wr_acc), .cut_req(cut_req),
    .busy_o(busy), .cut_o(cut), .last_o(last), .mask_o(dm_o)
  );

  assign pre_ok_o = pre_ok;
  assign act_ok_o = act_ok;
  assign pre_o    = pre_fire;
  assign dqs_en_o = busy;
endmodule

// File: rtl/wpg_checker.sv
module wpg_checker #(
  parameter int unsigned CNT_W = 6,
  parameter int unsigned BEATS = 2
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] cfg_twr,
  input logic [CNT_W-1:0] cfg_tras,
  input logic [CNT_W-1:0] cfg_trp,
  input logic             act_i,
  input logic             act_ok_o,
  input logic             pre_ok_o,
  input logic             pre_o,
  input logic             dqs_en_o,
  input logic [BEATS-1:0] dm_o
);
  localparam logic [15:0] SAT = 16'hFFFF;
  logic [15:0] since_act, since_data, since_pre;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_act  <= SAT;
      since_data <= SAT;
      since_pre  <= SAT;
    end else begin
      if (act_i && act_ok_o)        since_act <= 16'd1;
      else if (since_act != SAT)    since_act <= since_act + 16'd1;
      if (dqs_en_o && dm_o == '0)   since_data <= 16'd1;
      else if (since_data != SAT)   since_data <= since_data + 16'd1;
      if (pre_o)                    since_pre <= 16'd1;
      else if (since_pre != SAT)    since_pre <= since_pre + 16'd1;
    end
  end

  AST_PRE_TRAS: assert property (@(posedge clk) disable iff (rst)
    pre_o |-> since_act >= 16'(cfg_tras)); // R3
  AST_PRE_TWR: assert property (@(posedge clk) disable iff (rst)
    pre_o |-> since_data > 16'(cfg_twr)); // R6
  AST_PRE_PULSE: assert property (@(posedge clk) disable iff (rst)
    pre_o |=> !pre_o); // R7
  AST_MASK_STROBE: assert property (@(posedge clk) disable iff (rst)
    (dm_o != '0) |-> dqs_en_o); // R8
  AST_ACT_TRP: assert property (@(posedge clk) disable iff (rst)
    act_ok_o |-> since_pre >= 16'(cfg_trp)); // R10
  AST_ACT_CLOSED: assert property (@(posedge clk) disable iff (rst)
    act_ok_o |-> !pre_ok_o); // R2
endmodule

bind wrpre_bank_guard wpg_checker #(.CNT_W(CNT_W), .BEATS(BEATS_PER_CLK)) u_chk (
  .clk(clk), .rst(rst), .cfg_twr(cfg_twr), .cfg_tras(cfg_tras), .cfg_trp(cfg_trp),
  .act_i(act_i), .act_ok_o(act_ok_o), .pre_ok_o(pre_ok_o), .pre_o(pre_o),
  .dqs_en_o(dqs_en_o), .dm_o(dm_o)
);

// File: tb/wrpre_bank_guard_tb.sv
module wrpre_bank_guard_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 6;
  localparam int NONE = 1000000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CW-1:0] cfg_twr = 6'd3, cfg_tras = 6'd6, cfg_trp = 6'd2;
  logic act_i = 0, wr_i = 0, wra_i = 0, pre_req_i = 0;
  logic pre_ok_o, act_ok_o, pre_o, dqs_en_o;
  logic [1:0] dm_o;

  int tests = 0, fails = 0;
  bit done = 0;
  string scn = "R1";

  int n = 0;
  int m_active = 0, m_pend = 0;
  int m_act = -NONE, m_pre = -NONE, m_bs = -NONE, m_cut = NONE, m_last = -NONE;

  always #(CLK_PERIOD/2) clk = ~clk;

  wrpre_bank_guard dut_i (
    .clk(clk), .rst(rst), .cfg_twr(cfg_twr), .cfg_tras(cfg_tras), .cfg_trp(cfg_trp),
    .act_i(act_i), .wr_i(wr_i), .wra_i(wra_i), .pre_req_i(pre_req_i),
    .pre_ok_o(pre_ok_o), .act_ok_o(act_ok_o), .pre_o(pre_o),
    .dqs_en_o(dqs_en_o), .dm_o(dm_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s (%s) cycle %0d: actual %0d expected %0d", req, scn, n, act, exp);
    end
  endtask

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic step(input bit a, input bit w, input bit wa, input bit p);
    int busy, masked, uncut, e_pre_ok, e_pre, e_act_ok;
    @(negedge clk);
    busy     = (n >= m_bs && n <= m_bs + 3);
    masked   = busy && (m_cut < n);
    uncut    = busy && !masked;
    e_pre_ok = m_active && (n >= m_act + imax(int'(cfg_tras), 1)) && !uncut &&
               (n >= m_last + 1 + int'(cfg_twr));
    e_pre    = m_pend && e_pre_ok;
    e_act_ok = !m_active && (n >= m_pre + imax(int'(cfg_trp), 1));
    chk("R6 pre_ok_o",  int'(pre_ok_o), e_pre_ok);
    chk("R7 pre_o",     int'(pre_o),    e_pre);
    chk("R10 act_ok_o", int'(act_ok_o), e_act_ok);
    chk("R4 dqs_en_o",  int'(dqs_en_o), busy);
    chk("R8 dm_o",      int'(dm_o),     masked ? 3 : 0);
    act_i = a; wr_i = w; wra_i = wa; pre_req_i = p;
    if (e_pre) begin m_active = 0; m_pend = 0; m_pre = n; end
    if (a && e_act_ok) begin
      m_active = 1; m_act = n;
    end else if (p && m_active && !m_pend) begin
      m_pend = 1;
      if (uncut && n != m_bs + 3) begin m_cut = n; m_last = n; end
    end else if ((w || wa) && m_active && !m_pend && !p) begin
      m_bs = n + 1; m_cut = NONE; m_last = n + 4;
      if (wa) m_pend = 1;
    end
    n++;
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) step(0, 0, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 pre_ok_o", int'(pre_ok_o), 0);
    chk("R1 act_ok_o", int'(act_ok_o), 1);
    chk("R1 pre_o",    int'(pre_o),    0);
    chk("R1 dqs_en_o", int'(dqs_en_o), 0);
    chk("R1 dm_o",     int'(dm_o),     0);
    idle(2);
    // R3: early request held until tRAS
    scn = "R3"; step(1,0,0,0); step(0,0,0,1); idle(12);
    // R6: precharge after an uncut burst and tWR
    scn = "R6"; step(1,0,0,0); idle(7); step(0,1,0,0); idle(6); step(0,0,0,1); idle(10);
    // R8: interrupt in the second data cycle
    scn = "R8"; step(1,0,0,0); idle(5); step(0,1,0,0); idle(1); step(0,0,0,1); idle(12);
    // R9 and R2: autoprecharge, activate retried every cycle
    scn = "R9"; step(1,0,0,0); idle(2); step(0,0,1,0);
    step(0,1,0,1);
    for (int i = 0; i < 16; i++) step(1,0,0,0);
    scn = "R2"; for (int i = 0; i < 8; i++) step(1,0,0,0);
    step(0,0,0,1); idle(10);
    // R5: random column write restarts the burst
    scn = "R5"; step(1,0,0,0); idle(6); step(0,1,0,0); idle(2); step(0,1,0,0); idle(2);
    step(0,0,0,1); idle(12);
    // R4 and R7: write and request on a closed bank are ignored
    scn = "R4"; step(0,1,0,0); idle(3); step(0,0,1,0); idle(5);
    scn = "R7"; step(0,0,0,1); idle(4);
    // R6 with short timings, request on the last data cycle (no cut)
    idle(20);
    cfg_twr = 6'd0; cfg_tras = 6'd1; cfg_trp = 6'd1;
    scn = "R6"; step(1,0,0,0); step(0,1,0,0); idle(3); step(0,0,0,1); idle(6);
    // R4: write in the same cycle as a request is dropped, cut right away
    scn = "R4"; step(1,0,0,0); step(0,1,0,1); idle(6);
    scn = "R8"; step(1,0,0,0); step(0,1,0,0); step(0,0,0,1); idle(8);
    scn = "R9"; step(1,0,0,0); step(0,0,1,0); idle(2); step(0,0,0,1); idle(8);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule